// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block moves an 18-bit word between two ports, A and B, in either direction. Each direction owns one storage register and four controls: an active-low output enable, a latch enable, a direction clock and an active-low clock enable. With the latch enable high the path is transparent and the output follows the input in the same cycle. With it low, the register holds its value. A rising edge of the direction clock, seen while the clock enable is low, loads the register. The two directions behave identically and are fully independent.

The design is synchronous to a system clock `clk`. The direction clocks are sampled on it, and an edge is a sampled 0 followed by a sampled 1, so direction clock rates from zero up to the target of 150 MHz need only a faster system clock. Three-state outputs are modelled by a drive flag per port: while the flag is low the port's data reads zero and the port counts as high impedance. Each data input has a companion "driven" flag. While that flag is low, bus hold replaces the floating input with the last driven value.

Top module: `busXcvr18`

## Requirements
- R1: With a direction's latch enable high and its output enable low, the output data equals that direction's effective input in the same cycle.
- R2: With the latch enable low and no accepted clock edge, the output shows the stored word and it stays unchanged.
- R3: With the latch enable low and the clock enable low, a direction clock sampled at 0 and then at 1 loads the effective input of that cycle into the register. The new value appears on the output from the next cycle.
- R4: While the clock enable is high, a rising direction clock edge leaves the stored word unchanged.
- R5: While a direction's output enable is high, its drive flag is 0 and its output data reads 0, whatever the storage holds.
- R6: The B-to-A direction (input `bIn`, output `aOut`) follows R1 to R5 using only its own controls, and is not affected by the A-to-B controls.
- R7: The effective input is the data input while its driven flag is 1. Otherwise it is the last value seen with the driven flag at 1, or 0 if there has been none since reset.
- R8: After the latch enable falls, the register holds the effective input of the last cycle in which the latch enable was high.
- R9: While reset (`rstN` low) is active, both registers, both bus-hold values and both sampled clocks are 0. The drive flags still follow the output enables.
- R10: The two output enables are never low together, so at most one port drives at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| aIn | input | 18 | A-side data input |
| aInDriven | input | 1 | 1 when aIn is driven; 0 engages bus hold |
| aOut | output | 18 | A-side data output (B-to-A path) |
| aDrive | output | 1 | 1 when aOut drives; 0 means high impedance |
| bIn | input | 18 | B-side data input |
| bInDriven | input | 1 | 1 when bIn is driven; 0 engages bus hold |
| bOut | output | 18 | B-side data output (A-to-B path) |
| bDrive | output | 1 | 1 when bOut drives; 0 means high impedance |
| abOeN | input | 1 | A-to-B output enable, active low |
| abLe | input | 1 | A-to-B latch enable, high = transparent |
| abClk | input | 1 | A-to-B direction clock |
| abClkEnN | input | 1 | A-to-B clock enable, active low |
| baOeN | input | 1 | B-to-A output enable, active low |
| baLe | input | 1 | B-to-A latch enable, high = transparent |
| baClk | input | 1 | B-to-A direction clock |
| baClkEnN | input | 1 | B-to-A clock enable, active low |

## Verification
The assertions assume that the environment never enables both directions' outputs at the same time. They also assume that control and data inputs change only between system clock edges, so every direction clock level is seen by at least one sample. The stimulus picks, for each cycle, exactly one of three output-enable patterns: A-to-B only, B-to-A only, or neither. All inputs are applied on the falling edge of `clk`, and the direction clocks are toggled at random, at most once per system cycle.

// File: rtl/xcvrPkg.sv
package xcvrPkg;
  // Strobes from one direction's control to its datapath
  typedef struct packed {
    logic load;   // write the storage register this cycle
    logic pass;   // transparent: output follows the effective input
    logic drive;  // output driven (not high impedance)
  } xcvrStrobe_t;
endpackage

// File: rtl/xcvrCtrl.sv
module xcvrCtrl
  import xcvrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        latchEn,
  input  logic        dirClk,
  input  logic        clkEnN,
  input  logic        outEnN,
  output xcvrStrobe_t strobe
);
  logic prevClk;
  logic clkRise;

  always_ff @(posedge clk) begin
    if (!rstN) prevClk <= 1'b0;
    else       prevClk <= dirClk;
  end

  assign clkRise = dirClk & ~prevClk;

  always_comb begin
    strobe.pass  = latchEn;
    strobe.drive = ~outEnN;
    strobe.load  = latchEn | (clkRise & ~clkEnN);
  end

  // R4
  gated_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!latchEn && clkEnN) |-> !strobe.load);
endmodule

// File: rtl/xcvrPath.sv
module xcvrPath
  import xcvrPkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  xcvrStrobe_t      strobe,
  input  logic [WIDTH-1:0] inData,
  input  logic             inDriven,
  output logic [WIDTH-1:0] outData,
  output logic             outDrive
);
  logic [WIDTH-1:0] heldIn;
  logic [WIDTH-1:0] effIn;
  logic [WIDTH-1:0] store;

  assign effIn = inDriven ? inData : heldIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldIn <= '0;
      store  <= '0;
    end else begin
      if (inDriven)    heldIn <= inData;
      if (strobe.load) store  <= effIn;
    end
  end

  always_comb begin
    outDrive = strobe.drive;
    if (!strobe.drive)    outData = '0;
    else if (strobe.pass) outData = effIn;
    else                  outData = store;
  end

  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !inDriven) |-> $stable(effIn));
endmodule

// File: rtl/busXcvr18.sv
module busXcvr18
  import xcvrPkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  input  logic             aInDriven,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive,
  input  logic [WIDTH-1:0] bIn,
  input  logic             bInDriven,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  input  logic             abOeN,
  input  logic             abLe,
  input  logic             abClk,
  input  logic             abClkEnN,
  input  logic             baOeN,
  input  logic             baLe,
  input  logic             baClk,
  input  logic             baClkEnN
);
  xcvrStrobe_t abStrobe, baStrobe;

  xcvrCtrl u_abCtrl (.clk(clk), .rstN(rstN), .latchEn(abLe), .dirClk(abClk),
                     .clkEnN(abClkEnN), .outEnN(abOeN), .strobe(abStrobe));
  xcvrPath #(.WIDTH(WIDTH)) u_abPath (.clk(clk), .rstN(rstN), .strobe(abStrobe),
                     .inData(aIn), .inDriven(aInDriven), .outData(bOut), .outDrive(bDrive));

  xcvrCtrl u_baCtrl (.clk(clk), .rstN(rstN), .latchEn(baLe), .dirClk(baClk),
                     .clkEnN(baClkEnN), .outEnN(baOeN), .strobe(baStrobe));
  xcvrPath #(.WIDTH(WIDTH)) u_baPath (.clk(clk), .rstN(rstN), .strobe(baStrobe),
                     .inData(bIn), .inDriven(bInDriven), .outData(aOut), .outDrive(aDrive));

  // R10
  contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(aDrive && bDrive));

  // R5
  tristate_ab_chk: assert property (@(posedge clk) disable iff (!rstN)
    abOeN |-> (!bDrive && bOut == '0));

  // R4
  latched_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!abLe && abClkEnN && !abOeN) ##1 (!abLe && !abOeN) |-> $stable(bOut));
endmodule

// File: tb/busXcvr18_bench.sv
module busXcvr18_bench;
  localparam int W = 18;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [W-1:0] din [2];
  logic drv [2], oeN [2], le [2], dck [2], cen [2];
  logic [W-1:0] aOutS, bOutS;
  logic aDrvS, bDrvS;

  logic [W-1:0] mStore [2];
  logic [W-1:0] mHold [2];
  logic mPrev [2];
  int cause [2];
  int errors = 0;
  int checks = 0;

  busXcvr18 u_busXcvr18 (
    .clk(clk), .rstN(rstN),
    .aIn(din[0]), .aInDriven(drv[0]), .aOut(aOutS), .aDrive(aDrvS),
    .bIn(din[1]), .bInDriven(drv[1]), .bOut(bOutS), .bDrive(bDrvS),
    .abOeN(oeN[0]), .abLe(le[0]), .abClk(dck[0]), .abClkEnN(cen[0]),
    .baOeN(oeN[1]), .baLe(le[1]), .baClk(dck[1]), .baClkEnN(cen[1]));

  function automatic logic [W-1:0] effOf(int d);
    return drv[d] ? din[d] : mHold[d];
  endfunction

  function automatic logic [W-1:0] expData(int d);
    if (oeN[d]) return '0;
    return le[d] ? effOf(d) : mStore[d];
  endfunction

  task automatic checkDir(int d, string forced);
    logic [W-1:0] act;
    logic actDrv;
    string tag;
    act    = (d == 0) ? bOutS : aOutS;
    actDrv = (d == 0) ? bDrvS : aDrvS;
    if (forced != "")   tag = forced;
    else if (oeN[d])    tag = "R5";
    else if (le[d])     tag = drv[d] ? "R1" : "R7";
    else if (cause[d] == 2) tag = "R3";
    else if (cause[d] == 3) tag = "R4";
    else if (cause[d] == 1) tag = "R8";
    else                tag = "R2";
    if (d == 1) tag = {"R6 ", tag};
    checks++;
    if (act !== expData(d) || actDrv !== !oeN[d]) begin
      errors++;
      $display("FAIL %s dir%0d: data=%h drive=%b expected data=%h drive=%b",
               tag, d, act, actDrv, expData(d), !oeN[d]);
    end
  endtask

  task automatic modelUpdate();
    for (int d = 0; d < 2; d++) begin
      logic [W-1:0] e;
      logic rise;
      e = effOf(d);
      rise = dck[d] && !mPrev[d];
      if (drv[d]) mHold[d] = din[d];
      if (le[d]) begin mStore[d] = e; cause[d] = 1; end
      else if (rise && !cen[d]) begin mStore[d] = e; cause[d] = 2; end
      else if (rise) cause[d] = 3;
      else cause[d] = 0;
      mPrev[d] = dck[d];
    end
  endtask

  // inputs are set at a falling edge before calling
  task automatic step();
    #1;
    checkDir(0, "");
    checkDir(1, "");
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic randomInputs();
    int m;
    m = $urandom % 3;
    for (int d = 0; d < 2; d++) begin
      oeN[d] = !(m == d);
      le[d]  = ($urandom % 4) == 0;
      dck[d] = $urandom % 2;
      cen[d] = ($urandom % 3) == 0;
      drv[d] = ($urandom % 4) != 0;
      din[d] = W'($urandom);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int d = 0; d < 2; d++) begin
      din[d] = W'($urandom); drv[d] = 1'b1; le[d] = 1'b0; dck[d] = 1'b0;
      cen[d] = 1'b0; mStore[d] = '0; mHold[d] = '0; mPrev[d] = 1'b0; cause[d] = 0;
    end
    oeN[0] = 1'b0; oeN[1] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R9: storage cleared in reset, drive follows enables
    checkDir(0, "R9");
    checkDir(1, "R9");
    rstN = 1'b1;
    @(negedge clk);

    // R8: latch falls, previous transparent value held
    din[0] = 18'h2A5C3; le[0] = 1'b1; step();
    din[0] = 18'h15A3C; le[0] = 1'b0; step();
    step();
    // R3: enabled edge
    din[0] = 18'h3F00F; dck[0] = 1'b1; step();
    step();
    // R4: blocked edge
    dck[0] = 1'b0; step();
    din[0] = 18'h00FFF; cen[0] = 1'b1; dck[0] = 1'b1; step();
    step();
    // R7: undriven input in transparent mode keeps last driven word
    drv[0] = 1'b0; din[0] = 18'h12345; le[0] = 1'b1; step();
    step();
    // R6 and R5: only B-to-A enabled
    oeN[0] = 1'b1; oeN[1] = 1'b0; le[1] = 1'b1; din[1] = 18'h0BEEF; step();
    le[1] = 1'b0; step();

    for (int i = 0; i < 3000; i++) begin
      randomInputs();
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule